// File: doc/BRIEF.md
# Clock Configuration Select Latch

This block decides which of four stored PLL configurations is active. It watches two general-purpose select pins. A programming-mode flag picks the source of the index. Each pin also has its own enable bit. On the first clock after the power-on reset is released, the block records the physical pin levels once. While programming mode is active, the index stays at that recorded value, so pin activity cannot switch configurations during a programming session. Outside programming mode, the index follows the live pins after a two-flop synchronizer, with each pin masked by its enable bit.

The enable bits sit in a small register inside the block. Reset sets them to all ones, and a single-cycle write strobe updates them. A masked pin reads as zero to the index logic. The power-up capture ignores the mask and always samples the physical pins. The register file, the serial programming interface and the PLL itself are outside this block.

Top module: `clk_cfg_select`

## Requirements
- R1: While power-on reset is asserted, and until the capture has happened, `cfg_idx` is 0.
- R2: On the third rising clock edge after `por_n` goes high (two edges of reset synchronization, then one capture edge), the block records the synchronized physical `sel_pin` levels, whatever the state of `prog_mode`.
- R3: While `prog_mode` is 1, `cfg_idx` equals the captured value, and changes on `sel_pin` have no effect on it.
- R4: While `prog_mode` is 0, `cfg_idx` bit i equals `sel_pin` bit i as seen through the two-flop synchronizer, ANDed with enable bit i. A pin change reaches the output two rising edges after it is applied.
- R5: After reset, every enable bit is 1, so both pins pass through unmasked.
- R6: A rising edge with `en_wr` = 1 loads `en_wdata` into the enable bits. Enable bit i masks `sel_pin` bit i, and a cleared bit makes that index bit read 0.
- R7: The captured value ignores the enable bits. Clearing the enable bits leaves `cfg_idx` at the captured value while in programming mode.
- R8: The captured value is held until the next power-on reset. A new reset captures the pins again.
- R9: With both pins low at power-up, configuration 0 is selected in programming mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asserted asynchronously |
| sel_pin | input | NUM_SEL | Raw configuration select pins (asynchronous) |
| prog_mode | input | 1 | 1 = programming mode, index held at the captured value |
| en_wr | input | 1 | Write strobe for the enable bits |
| en_wdata | input | NUM_SEL | New enable bits; bit i = 1 lets `sel_pin` bit i through |
| cfg_idx | output | NUM_SEL | Active configuration index |

## Verification
The bench builds the block with its default parameters: two select pins, giving four configurations, and a two-stage synchronizer. With two pins, every mix of enable mask and pin pattern fits in a short vector table, including the partial masks where one pin passes and the other is forced low. The two-stage depth also fixes the capture at the third edge after reset release, so the bench can check the output as zero at the second edge and as the pin value at the third. Repeated resets with different pin levels and mode states cover recapture and the all-low default.

// File: rtl/cfgsel_pkg.sv
package cfgsel_pkg;

  // Source of the active configuration index
  typedef enum logic {
    SRC_LIVE     = 1'b0,
    SRC_CAPTURED = 1'b1
  } idx_src_e;

endpackage

// File: rtl/cfgsel_rst_sync.sv
module cfgsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/cfgsel_pin_sync.sv
module cfgsel_pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d_i;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage_q[s] <= '0;
        else         stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/cfgsel_capture.sv
module cfgsel_capture #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] cap_o,
  output logic             done_o
);

  logic [WIDTH-1:0] cap_q, cap_d;
  logic             done_q, done_d;
  logic             load_en;

  always_comb begin
    load_en = !done_q;
    cap_d   = cap_q;
    done_d  = done_q;
    if (load_en) begin
      cap_d  = pins_i;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      done_q <= done_d;
    end
  end

  assign cap_o  = cap_q;
  assign done_o = done_q;

  // R2: the first load takes the pin value present on the previous cycle
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> cap_q == $past(pins_i));

  // R8: once captured, the value and flag stay until reset
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> (done_q && $stable(cap_q)));

endmodule

// File: rtl/cfgsel_en_reg.sv
module cfgsel_en_reg #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] en_o
);

  logic [WIDTH-1:0] en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (wr_i) en_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '1;
    else        en_q <= en_d;
  end

  assign en_o = en_q;

  // R6: a strobed write lands in the enable bits on the next cycle
  a_r6_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_i)) |-> en_q == $past(wdata_i));

endmodule

// File: rtl/clk_cfg_select.sv
module clk_cfg_select #(
  parameter int NUM_SEL     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic [NUM_SEL-1:0] sel_pin,
  input  logic               prog_mode,
  input  logic               en_wr,
  input  logic [NUM_SEL-1:0] en_wdata,
  output logic [NUM_SEL-1:0] cfg_idx
);
  import cfgsel_pkg::*;

  localparam int NUM_CFG = 1 << NUM_SEL;

  logic               rst_int_n;
  logic [NUM_SEL-1:0] pins_sync;
  logic [NUM_SEL-1:0] cap_idx;
  logic               cap_done;
  logic [NUM_SEL-1:0] en_bits;
  logic [NUM_SEL-1:0] live_idx;
  idx_src_e           src;

  cfgsel_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (por_n),
    .rst_n_o (rst_int_n)
  );

  // Synchronizer runs from the raw reset so it is filled by capture time
  cfgsel_pin_sync #(.WIDTH(NUM_SEL), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk    (clk),
    .arst_n (por_n),
    .d_i    (sel_pin),
    .q_o    (pins_sync)
  );

  cfgsel_capture #(.WIDTH(NUM_SEL)) u_capture (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pins_i (pins_sync),
    .cap_o  (cap_idx),
    .done_o (cap_done)
  );

  cfgsel_en_reg #(.WIDTH(NUM_SEL)) u_en_reg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_i    (en_wr),
    .wdata_i (en_wdata),
    .en_o    (en_bits)
  );

  genvar i;
  generate
    for (i = 0; i < NUM_SEL; i++) begin : g_mask
      assign live_idx[i] = pins_sync[i] & en_bits[i];
    end
  endgenerate

  always_comb begin
    src = prog_mode ? SRC_CAPTURED : SRC_LIVE;
    if (!cap_done)                cfg_idx = '0;
    else if (src == SRC_CAPTURED) cfg_idx = cap_idx;
    else                          cfg_idx = live_idx;
  end

  // R3: in programming mode the index does not move
  a_r3_prog_stable: assert property (@(posedge clk) disable iff (!rst_int_n)
    (prog_mode && $past(prog_mode) && $past(cap_done)) |-> $stable(cfg_idx));

  // R1: index is zero until the capture completes
  a_r1_zero_before_capture: assert property (@(posedge clk) disable iff (!por_n)
    !cap_done |-> cfg_idx == '0);

  initial begin
    if (NUM_CFG < 2) $error("NUM_SEL must be at least 1");
  end

endmodule

// File: tb/clk_cfg_select_tb.sv
module clk_cfg_select_tb;

  localparam int NSEL = 2;
  localparam int NVEC = 9;
  // {enable bits, pins, expected index}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b11_00_00, 6'b11_01_01, 6'b11_10_10, 6'b11_11_11,
    6'b01_11_01, 6'b10_11_10, 6'b00_11_00, 6'b10_01_00,
    6'b01_10_00
  };

  logic            clk = 1'b0;
  logic            por_n;
  logic [NSEL-1:0] sel_pin;
  logic            prog_mode;
  logic            en_wr;
  logic [NSEL-1:0] en_wdata;
  logic [NSEL-1:0] cfg_idx;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  clk_cfg_select #(.NUM_SEL(NSEL), .SYNC_STAGES(2)) u_dut (
    .clk       (clk),
    .por_n     (por_n),
    .sel_pin   (sel_pin),
    .prog_mode (prog_mode),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .cfg_idx   (cfg_idx)
  );

  task automatic check(input string req, input logic [NSEL-1:0] exp);
    n_chk++;
    if (cfg_idx !== exp) begin
      n_fail++;
      $display("FAIL %s: cfg_idx=%b expected=%b", req, cfg_idx, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic write_en(input logic [NSEL-1:0] v);
    en_wdata = v;
    en_wr    = 1'b1;
    @(negedge clk);
    en_wr    = 1'b0;
  endtask

  // Reset with given pins and mode; returns at the negedge after the 2nd post-release edge
  task automatic do_reset(input logic [NSEL-1:0] p, input logic pm);
    @(negedge clk);
    por_n     = 1'b0;
    sel_pin   = p;
    prog_mode = pm;
    cycles(3);
    check("R1 in reset", '0);
    por_n = 1'b1;
    cycles(2);
    check("R1 before capture", '0);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: cfg_idx=%b expected=done", cfg_idx);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    por_n = 1'b0; sel_pin = '0; prog_mode = 1'b1; en_wr = 1'b0; en_wdata = '0;

    // R2, R3: capture 10 in programming mode
    do_reset(2'b10, 1'b1);
    cycles(1);
    check("R2 capture", 2'b10);
    sel_pin = 2'b01;
    cycles(4);
    check("R3 pins ignored in prog mode", 2'b10);
    // R7: clearing enables leaves the captured index
    write_en(2'b00);
    cycles(3);
    check("R7 capture ignores enables", 2'b10);

    // R5: enables reset to ones, live pins pass
    do_reset(2'b11, 1'b0);
    cycles(1);
    check("R2 capture with prog_mode low", 2'b11);
    sel_pin = 2'b01;
    cycles(3);
    check("R5 R4 live path unmasked after reset", 2'b01);
    // R4: two-edge latency
    sel_pin = 2'b10;
    cycles(1);
    check("R4 one edge not yet", 2'b01);
    cycles(1);
    check("R4 after two edges", 2'b10);
    prog_mode = 1'b1;
    #1;
    check("R2 R8 captured while prog_mode was low", 2'b11);
    prog_mode = 1'b0;

    // R4, R6: vector table
    for (int v = 0; v < NVEC; v++) begin
      write_en(VEC[v][5:4]);
      sel_pin = VEC[v][3:2];
      cycles(3);
      check($sformatf("R6 R4 vector %0d", v), VEC[v][1:0]);
    end

    // R8, R9: recapture with pins low
    do_reset(2'b00, 1'b1);
    cycles(1);
    check("R9 default config 0", 2'b00);
    sel_pin = 2'b11;
    cycles(4);
    check("R8 R3 hold after recapture", 2'b00);
    prog_mode = 1'b0;
    cycles(1);
    check("R4 live after leaving prog mode", 2'b11);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule